// File: doc/BRIEF.md
# Core Input Pin Front-End

This block sits between a processor core's raw control pins and its exception and reset logic. Seven input pins are involved: external interrupt, system management interrupt, machine check, checkstop, hard reset, soft reset and time-base enable. Each pin passes through a two-flop synchroniser. The block compares the result with a stored copy of the last level it acted on. It produces an event only when the two differ. Each pin then applies its own sensitivity: active-high level, active-low level, or falling edge.

The outputs are a four-bit pending-interrupt vector, a summary request line that is high while any pending bit is set, a sticky halt request, a one-cycle core reset pulse and a time-base run/freeze control. The machine-check pending bit is the only one that latches. The exception logic clears it with an acknowledge strobe. The level-sensitive bits simply follow their pins.

Top module: `cpf_top`

## Requirements
- R1: After reset, pend_o, irq_o, halt_o, core_rst_o and tb_run_o are all 0.
- R2: pins_i[0] (external interrupt, active high) drives pend_o[0] to follow its level.
- R3: pins_i[1] (system management interrupt, active high) drives pend_o[1] to follow its level.
- R4: A 1-to-0 change on pins_i[2] (machine check) sets pend_o[2]. A 0-to-1 change leaves it unchanged. mchk_ack_i clears it on the next clock edge. When a falling edge and the acknowledge take effect on the same edge, the set wins.
- R5: A change of pins_i[3] (checkstop, active low) to 0 sets halt_o. Releasing the pin to 1 does not clear halt_o. Only rst_ni clears it.
- R6: A change of pins_i[4] (hard reset, active low) to 0 produces a core_rst_o pulse exactly one cycle long. A change back to 1 produces no pulse.
- R7: pins_i[5] (soft reset, active high) drives pend_o[3] to follow its level.
- R8: pins_i[6] (time-base enable) sets tb_run_o to 1 when high (run) and to 0 when low (freeze).
- R9: irq_o is 1 exactly when pend_o is not all zero.
- R10: Driving a pin to the level it already holds produces no event. A machine-check pin held low after an acknowledge does not set pend_o[2] again.
- R11: After a pin change, all outputs keep their old values through the second rising clock edge and take the new values at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 7 | Raw pin levels, bit positions as in R2 to R8 |
| mchk_ack_i | input | 1 | Clears the machine-check pending bit |
| pend_o | output | 4 | Pending vector: 0 ext, 1 SMI, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Summary interrupt request |
| halt_o | output | 1 | Sticky halt request from checkstop |
| core_rst_o | output | 1 | One-cycle core reset request |
| tb_run_o | output | 1 | Time base runs when 1, frozen when 0 |

## Verification
A pin change driven between edges becomes visible after the third rising edge: two synchroniser stages, then the output register. The acknowledge strobe takes effect after one edge. For every stimulus, the driver queues three expectations stamped with the cycle in which each is due: the unchanged values at edge two, the new values at edge three, and the reset pulse already gone at edge four. The monitor compares a queued item at the falling edge of exactly the cycle stamped on it. A result that arrives one cycle early or late, or a pulse longer than one cycle, therefore fails the check.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

  // Pin positions on the input vector
  localparam int PIN_EXT   = 0;
  localparam int PIN_SMI   = 1;
  localparam int PIN_MCHK  = 2;
  localparam int PIN_CSTOP = 3;
  localparam int PIN_HRST  = 4;
  localparam int PIN_SRST  = 5;
  localparam int PIN_TBEN  = 6;
  localparam int PIN_COUNT = 7;

  // Pending vector positions
  localparam int PND_EXT  = 0;
  localparam int PND_SMI  = 1;
  localparam int PND_MCHK = 2;
  localparam int PND_SRST = 3;
  localparam int PND_W    = 4;

  // Level-driven pending updates handed to the pending register
  typedef struct packed {
    logic ext_chg;
    logic ext_lvl;
    logic smi_chg;
    logic smi_lvl;
    logic srst_chg;
    logic srst_lvl;
    logic mchk_fall;
  } pend_evt_t;

  // Inactive level of each pin: active-low pins rest high
  function automatic logic [31:0] idle_mask();
    logic [31:0] m;
    m = '0;
    m[PIN_MCHK]  = 1'b1;
    m[PIN_CSTOP] = 1'b1;
    m[PIN_HRST]  = 1'b1;
    return m;
  endfunction

  // A change to low seen on a pin
  function automatic logic went_low(logic changed, logic new_lvl);
    return changed & ~new_lvl;
  endfunction

endpackage

// File: rtl/cpf_sync.sv
module cpf_sync #(
  parameter int W = 7,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st1_q, st2_q;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st1_q[gi] <= IDLE[gi];
        st2_q[gi] <= IDLE[gi];
      end else begin
        st1_q[gi] <= d_i[gi];
        st2_q[gi] <= st1_q[gi];
      end
    end
  end

  assign q_o = st2_q;
endmodule

// File: rtl/cpf_detect.sv
module cpf_detect
  import cpf_pkg::*;
#(
  parameter int W = PIN_COUNT,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [W-1:0] lvl_s_i,
  output pend_evt_t  pevt_o,
  output logic       cstop_enter_o,
  output logic       hrst_enter_o,
  output logic       tb_run_o
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] chg;

  for (genvar gi = 0; gi < W; gi++) begin : g_pin
    assign chg[gi] = lvl_s_i[gi] ^ lvl_q[gi];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lvl_q[gi] <= IDLE[gi];
      else if (chg[gi])   lvl_q[gi] <= lvl_s_i[gi];
    end
  end

  always_comb begin
    pevt_o.ext_chg   = chg[PIN_EXT];
    pevt_o.ext_lvl   = lvl_s_i[PIN_EXT];
    pevt_o.smi_chg   = chg[PIN_SMI];
    pevt_o.smi_lvl   = lvl_s_i[PIN_SMI];
    pevt_o.srst_chg  = chg[PIN_SRST];
    pevt_o.srst_lvl  = lvl_s_i[PIN_SRST];
    pevt_o.mchk_fall = went_low(chg[PIN_MCHK], lvl_s_i[PIN_MCHK]);
  end

  assign cstop_enter_o = went_low(chg[PIN_CSTOP], lvl_s_i[PIN_CSTOP]);
  assign hrst_enter_o  = went_low(chg[PIN_HRST],  lvl_s_i[PIN_HRST]);
  assign tb_run_o      = lvl_q[PIN_TBEN];

  // R10
  stored_moves_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(|chg));
endmodule

// File: rtl/cpf_pend.sv
module cpf_pend
  import cpf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pend_evt_t        pevt_i,
  input  logic             mchk_ack_i,
  output logic [PND_W-1:0] pend_o
);
  logic [PND_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      if (pevt_i.ext_chg)  pend_q[PND_EXT]  <= pevt_i.ext_lvl;
      if (pevt_i.smi_chg)  pend_q[PND_SMI]  <= pevt_i.smi_lvl;
      if (pevt_i.srst_chg) pend_q[PND_SRST] <= pevt_i.srst_lvl;
      if (pevt_i.mchk_fall)  pend_q[PND_MCHK] <= 1'b1;
      else if (mchk_ack_i)   pend_q[PND_MCHK] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R4
  mchk_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pevt_i.mchk_fall |=> pend_q[PND_MCHK]);

  // R10
  mchk_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[PND_MCHK]) |-> $past(pevt_i.mchk_fall));
endmodule

// File: rtl/cpf_top.sv
module cpf_top
  import cpf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_COUNT-1:0] pins_i,
  input  logic                 mchk_ack_i,
  output logic [PND_W-1:0]     pend_o,
  output logic                 irq_o,
  output logic                 halt_o,
  output logic                 core_rst_o,
  output logic                 tb_run_o
);
  localparam logic [PIN_COUNT-1:0] IDLE = PIN_COUNT'(idle_mask());

  logic [PIN_COUNT-1:0] lvl_s;
  pend_evt_t            pevt;
  logic                 cstop_enter, hrst_enter;
  logic                 halt_q, rst_q;

  cpf_sync #(.W(PIN_COUNT), .IDLE(IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(lvl_s)
  );

  cpf_detect #(.W(PIN_COUNT), .IDLE(IDLE)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_s_i(lvl_s),
    .pevt_o(pevt), .cstop_enter_o(cstop_enter),
    .hrst_enter_o(hrst_enter), .tb_run_o(tb_run_o)
  );

  cpf_pend u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .pevt_i(pevt),
    .mchk_ack_i(mchk_ack_i), .pend_o(pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (cstop_enter) halt_q <= 1'b1;
      rst_q <= hrst_enter;
    end
  end

  assign halt_o     = halt_q;
  assign core_rst_o = rst_q;
  assign irq_o      = |pend_o;

  // R5
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R6
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> !core_rst_o);

  // R6
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> $past(hrst_enter));
endmodule

// File: tb/tb_cpf_top.sv
module tb_cpf_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pins = 7'b0011100;
  logic       ack = 1'b0;
  logic [3:0] pend;
  logic       irq, halt, crst, tbr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [6:0] m_pins = 7'b0011100;
  logic [3:0] m_pend = '0;
  logic       m_halt = 1'b0;
  logic       m_tb   = 1'b0;

  typedef struct {
    int         due;
    logic [3:0] pend;
    logic       halt;
    logic       rst;
    logic       tb;
    string      tag;
  } exp_t;
  exp_t sb[$];
  exp_t it;

  cpf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .mchk_ack_i(ack),
    .pend_o(pend), .irq_o(irq), .halt_o(halt), .core_rst_o(crst), .tb_run_o(tbr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push_exp(int due, string tag, logic rstv);
    exp_t e;
    e.due = due; e.pend = m_pend; e.halt = m_halt;
    e.rst = rstv; e.tb = m_tb; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare each item in the cycle it is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      checks++;
      if (it.due != cyc ||
          {pend, irq, halt, crst, tbr} !== {it.pend, |it.pend, it.halt, it.rst, it.tb}) begin
        errors++;
        $display("FAIL %s cyc=%0d: actual pend=%b irq=%b halt=%b rst=%b tb=%b expected pend=%b irq=%b halt=%b rst=%b tb=%b",
                 it.tag, cyc, pend, irq, halt, crst, tbr,
                 it.pend, |it.pend, it.halt, it.rst, it.tb);
      end
    end
  end

  function automatic string tag_of(int idx);
    case (idx)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // driver: change one pin, queue old / new / settled expectations
  task automatic drive_pin(int idx, logic v, string tag = "");
    logic pulse;
    string t;
    t = (tag == "") ? tag_of(idx) : tag;
    @(negedge clk);
    pulse = 1'b0;
    push_exp(cyc + 2, "R11", 1'b0);
    if (m_pins[idx] != v) begin
      case (idx)
        0: m_pend[0] = v;
        1: m_pend[1] = v;
        2: if (!v) m_pend[2] = 1'b1;
        3: if (!v) m_halt = 1'b1;
        4: pulse = !v;
        5: m_pend[3] = v;
        default: m_tb = v;
      endcase
    end
    m_pins[idx] = v;
    pins[idx] = v;
    push_exp(cyc + 3, t, pulse);
    push_exp(cyc + 4, t, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_mchk();
    @(negedge clk);
    ack = 1'b1;
    m_pend[2] = 1'b0;
    push_exp(cyc + 1, "R4", 1'b0);
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  // falling edge and acknowledge land on the same clock edge
  task automatic fall_with_ack();
    @(negedge clk);
    pins[2] = 1'b0;
    m_pins[2] = 1'b0;
    repeat (2) @(negedge clk);
    ack = 1'b1;
    m_pend[2] = 1'b1;
    push_exp(cyc + 1, "R4", 1'b0);
    @(negedge clk);
    ack = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_pend = '0; m_halt = 1'b0; m_tb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    push_exp(cyc + 1, "R1", 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_exp(cyc + 1, "R1", 1'b0);
    repeat (2) @(negedge clk);

    // R2, R3, R9: level interrupts and summary line
    drive_pin(0, 1'b1);
    drive_pin(1, 1'b1);
    drive_pin(0, 1'b0, "R9");
    drive_pin(1, 1'b0, "R9");
    // R7 soft reset level
    drive_pin(5, 1'b1);
    drive_pin(5, 1'b0);
    // R8 time base
    drive_pin(6, 1'b1);
    drive_pin(6, 1'b0);
    drive_pin(6, 1'b1);
    // R4 machine check edge behaviour
    drive_pin(2, 1'b0);
    drive_pin(2, 1'b1);
    ack_mchk();
    drive_pin(2, 1'b1, "R10");
    drive_pin(2, 1'b0);
    ack_mchk();
    drive_pin(2, 1'b0, "R10");
    drive_pin(2, 1'b1);
    fall_with_ack();
    ack_mchk();
    drive_pin(2, 1'b1);
    // R6 hard reset pulse
    drive_pin(4, 1'b0);
    drive_pin(4, 1'b1);
    drive_pin(4, 1'b1, "R10");
    // R5 checkstop
    drive_pin(3, 1'b0);
    drive_pin(3, 1'b1);
    drive_pin(6, 1'b0);
    do_reset();
    drive_pin(0, 1'b1, "R1");
    drive_pin(0, 1'b0, "R1");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R11: actual %0d unchecked items, expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule